// File: doc/BRIEF.md
# Pattern-Matching Serial Byte Receiver

This block receives 8N1 asynchronous serial bytes without any bit-timing state machine. A tick input, pulsed once per sample at three times the bit rate, shifts the synchronised line level into a 32-sample history register. On every clock the block checks that register for a complete frame. A frame is complete when the oldest end holds an idle-to-start edge and the stop-bit position one frame length later holds a high level. When a frame matches, the block reads the eight data bits from fixed taps, presents the byte with a one-cycle strobe, and zeroes the history.

A frame that fails the match is never reported and does not disturb the history. A short noise pulse ahead of a real start bit therefore produces a false edge that fails to match. The real start edge behind it is still found once it reaches the oldest end. The surrounding logic provides the sample tick and consumes the byte and strobe.

Top module: `frame_window_rx`

## Requirements
- R1: After reset `rx_valid` is 0 and `rx_byte` is 0, and a line held idle high produces no strobe.
- R2: A frame sent at 3 samples per bit, as 3 low start samples, then 8 data bits least-significant first (3 samples each), then 3 high stop samples, followed by at least one idle high sample, yields exactly one `rx_valid` pulse of one clock cycle, with `rx_byte` equal to the data. Counting from the first low start sample, data bit k is taken from the sample 4+3k later and the stop level from the sample 28 later.
- R3: `rx_byte` changes only in a cycle where `rx_valid` is 1, and otherwise holds the last received byte.
- R4: A frame whose stop samples are low produces no strobe and leaves `rx_byte` unchanged, and a correct frame sent afterwards is received.
- R5: A single low sample, followed by a single high sample and then a correct frame whose data bit 7 is 0, yields exactly one strobe carrying that frame's byte.
- R6: After a match the history is all zeros, so a new start edge is recognised only if a high sample was shifted in after the match. If a correct frame is followed by one idle sample and then a second frame, the second frame is not reported. With two idle samples between them, both frames are reported.
- R7: The line is sampled only in cycles where `tick` is 1. A low pulse on `rxd` that has passed the synchroniser before the next tick has no effect on the received bytes or strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Sample enable, one pulse per sample at 3x the bit rate |
| rxd | input | 1 | Serial line, idle high, asynchronous |
| rx_byte | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe when `rx_byte` is updated |

## Verification
The hardest case to reach from the ports is a false start edge that lies in the history ahead of a real one, because its stop tap must land on a low data sample for it to fail. The stimulus sends one low sample and one high sample directly in front of a frame whose bit 7 is low, so the false edge's stop tap falls on the last bit-7 sample. The bench then checks that exactly the real byte comes out. The clearing rule is driven by placing frames with one and with two idle samples between them. The second byte in that test has no internal falling edge, so a lost frame cannot leave behind a false match.

// File: rtl/fwr_pkg.sv
package fwr_pkg;
  localparam int unsigned SAMPLES_PER_BIT = 3;
  localparam int unsigned DATA_BITS       = 8;
  localparam int unsigned WINDOW_LEN      = 32;
  localparam int unsigned SYNC_STAGES     = 2;
endpackage

// File: rtl/fwr_line_sync.sv
// Multi-stage synchroniser for the asynchronous serial line; resets to idle high.
module fwr_line_sync #(
  parameter int unsigned STAGES = fwr_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/fwr_window.sv
// Sample history: shifts on tick, newest sample at bit 0; clear has priority.
module fwr_window #(
  parameter int unsigned WIN = fwr_pkg::WINDOW_LEN
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           clear,
  input  logic           din,
  output logic [WIN-1:0] hist
);
  logic [WIN-1:0] hist_d;

  always_comb begin
    hist_d = hist;
    if (clear)     hist_d = '0;
    else if (tick) hist_d = {hist[WIN-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= hist_d;
  end

  // R7: without a tick or a clear, the history does not move
  a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear) |=> $stable(hist));
endmodule

// File: rtl/fwr_match.sv
// Frame pattern match over the history window and registered byte output.
module fwr_match #(
  parameter int unsigned WIN = fwr_pkg::WINDOW_LEN,
  parameter int unsigned SPB = fwr_pkg::SAMPLES_PER_BIT,
  parameter int unsigned DB  = fwr_pkg::DATA_BITS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [WIN-1:0] hist,
  output logic           hit,
  output logic [DB-1:0]  byte_q,
  output logic           valid_q
);
  localparam int unsigned IDLE_TAP = WIN - 1;
  localparam int unsigned EDGE_TAP = WIN - 2;
  localparam int unsigned STOP_TAP = EDGE_TAP - (SPB * (DB + 1) + 1);

  logic [DB-1:0] taps;
  logic [DB-1:0] byte_d;
  logic          valid_d;

  for (genvar k = 0; k < DB; k++) begin : g_tap
    assign taps[k] = hist[EDGE_TAP - (SPB * (k + 1) + 1)];
  end

  assign hit = hist[IDLE_TAP] & ~hist[EDGE_TAP] & hist[STOP_TAP];

  always_comb begin
    valid_d = hit;
    byte_d  = hit ? taps : byte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      byte_q  <= '0;
    end else begin
      valid_q <= valid_d;
      byte_q  <= byte_d;
    end
  end

  // R2: the strobe lasts exactly one cycle
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R3: the byte only moves together with the strobe
  a_r3_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byte_q) |-> valid_q);
endmodule

// File: rtl/frame_window_rx.sv
module frame_window_rx #(
  parameter int unsigned SPB       = fwr_pkg::SAMPLES_PER_BIT,
  parameter int unsigned DATA_BITS = fwr_pkg::DATA_BITS,
  parameter int unsigned WIN       = fwr_pkg::WINDOW_LEN,
  parameter int unsigned SYNC      = fwr_pkg::SYNC_STAGES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rxd,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_valid
);
  logic [1:0]     rst_pipe;
  logic           rst_int_n;
  logic           line_s;
  logic           hit;
  logic [WIN-1:0] hist;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  fwr_line_sync #(.STAGES(SYNC)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  (rxd),
    .dout (line_s)
  );

  fwr_window #(.WIN(WIN)) u_win (
    .clk  (clk),
    .rst_n(rst_int_n),
    .tick (tick),
    .clear(hit),
    .din  (line_s),
    .hist (hist)
  );

  fwr_match #(.WIN(WIN), .SPB(SPB), .DB(DATA_BITS)) u_match (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .hist   (hist),
    .hit    (hit),
    .byte_q (rx_byte),
    .valid_q(rx_valid)
  );

  // R6: a match empties the whole history
  a_r6_clear_after_hit: assert property (@(posedge clk) disable iff (!rst_int_n)
    hit |=> (hist == '0));
  // R2: every strobe follows a detected pattern
  a_r2_strobe_from_hit: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rx_valid) |-> $past(hit));
endmodule

// File: tb/sim_frame_window_rx.sv
module sim_frame_window_rx;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       rxd;
  logic [7:0] rx_byte;
  logic       rx_valid;

  int total = 0;
  int bad = 0;
  int strobes = 0;
  int long_strobes = 0;
  logic [7:0] last_byte = 8'h00;
  logic prev_valid = 1'b0;
  logic run = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  frame_window_rx u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  always @(negedge clk) begin
    if (run) begin
      if (rx_valid) begin
        strobes++;
        last_byte = rx_byte;
        if (prev_valid) long_strobes++;
      end
      prev_valid = rx_valid;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one sample period = 6 clocks; optional inter-tick dip on high samples
  task automatic push(input logic b, input logic dip);
    rxd = b;
    @(negedge clk); if (dip && b) rxd = 1'b0;
    @(negedge clk); rxd = b;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic idle(input int n, input logic dip);
    for (int i = 0; i < n; i++) push(1'b1, dip);
  endtask

  task automatic frame(input logic [7:0] d, input logic stop, input logic dip);
    for (int i = 0; i < 3; i++) push(1'b0, dip);
    for (int k = 0; k < 8; k++)
      for (int i = 0; i < 3; i++) push(d[k], dip);
    for (int i = 0; i < 3; i++) push(stop, dip);
  endtask

  task automatic t_reset;
    check(rx_valid == 1'b0, "R1 valid after reset", rx_valid, 0);
    check(rx_byte == 8'h00, "R1 byte after reset", rx_byte, 0);
    idle(40, 1'b0);
    check(strobes == 0, "R1 idle line strobes", strobes, 0);
  endtask

  task automatic t_basic(input logic [7:0] d);
    int s0 = strobes;
    frame(d, 1'b1, 1'b0);
    idle(3, 1'b0);
    check(strobes == s0 + 1, "R2 strobe count", strobes - s0, 1);
    check(last_byte == d, "R2 byte value", last_byte, d);
    check(long_strobes == 0, "R2 strobe width", long_strobes, 0);
    idle(4, 1'b0);
    check(rx_byte == d, "R3 byte held", rx_byte, d);
  endtask

  task automatic t_framing;
    int s0 = strobes;
    logic [7:0] keep = rx_byte;
    frame(8'h00, 1'b0, 1'b0);
    idle(5, 1'b0);
    check(strobes == s0, "R4 no strobe on bad stop", strobes - s0, 0);
    check(rx_byte == keep, "R4 byte unchanged", rx_byte, keep);
    frame(8'h5A, 1'b1, 1'b0);
    idle(3, 1'b0);
    check(strobes == s0 + 1 && last_byte == 8'h5A, "R4 next frame received", last_byte, 8'h5A);
  endtask

  task automatic t_glitch;
    int s0 = strobes;
    idle(6, 1'b0);
    push(1'b0, 1'b0);
    push(1'b1, 1'b0);
    frame(8'h35, 1'b1, 1'b0);
    idle(4, 1'b0);
    check(strobes == s0 + 1, "R5 one strobe after glitch", strobes - s0, 1);
    check(last_byte == 8'h35, "R5 byte after glitch", last_byte, 8'h35);
  endtask

  task automatic t_gap;
    int s0;
    idle(4, 1'b0);
    s0 = strobes;
    frame(8'h81, 1'b1, 1'b0);
    idle(1, 1'b0);
    frame(8'hF0, 1'b1, 1'b0);
    idle(6, 1'b0);
    check(strobes == s0 + 1, "R6 one idle sample loses second frame", strobes - s0, 1);
    check(last_byte == 8'h81, "R6 first byte kept", last_byte, 8'h81);
    s0 = strobes;
    frame(8'h81, 1'b1, 1'b0);
    idle(2, 1'b0);
    frame(8'hF0, 1'b1, 1'b0);
    idle(3, 1'b0);
    check(strobes == s0 + 2, "R6 two idle samples keep both", strobes - s0, 2);
    check(last_byte == 8'hF0, "R6 second byte", last_byte, 8'hF0);
  endtask

  task automatic t_dips;
    int s0 = strobes;
    idle(20, 1'b1);
    check(strobes == s0, "R7 dips on idle ignored", strobes - s0, 0);
    frame(8'h96, 1'b1, 1'b1);
    idle(3, 1'b1);
    check(strobes == s0 + 1, "R7 strobe with dips", strobes - s0, 1);
    check(last_byte == 8'h96, "R7 byte with dips", last_byte, 8'h96);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    tick = 1'b0;
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run = 1'b1;
    t_reset();
    t_basic(8'hA5);
    t_basic(8'h00);
    t_basic(8'hFF);
    t_basic(8'h3C);
    t_framing();
    t_glitch();
    t_gap();
    t_dips();
    check(long_strobes == 0, "R2 no multi-cycle strobe overall", long_strobes, 0);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule